// File: doc/BRIEF.md
# Four-Level Interrupt Control Register

This block is a 16-bit memory-mapped register that gathers four external interrupt request lines and decides whether one of them reaches the processor. The register holds a pending bit for each level, a delivery mask bit for each level, one global enable bit and an idle flag. The idle flag is 1 while no handler runs and 0 while one does. An interrupt is offered to the processor only when the idle flag and the global enable are both set and at least one pending level is also unmasked. The highest such level is reported on a 2-bit level code.

The processor takes the offered interrupt with a one-cycle acknowledge strobe. That strobe clears the winning level's pending bit and drops the idle flag, so no second interrupt can arrive while the handler runs. A one-cycle return strobe raises the idle flag again. Software reads the whole register on a combinational read port and rewrites it with a write enable and a 16-bit data word. A request line sets its pending bit on a rising level. A software write of 0 clears a pending bit, and a write of 1 sets it.

Top module: `irq_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x0200: pending bits, masks and global enable are 0, the idle flag is 1, and `irq_o` is 0.
- R2: The read word has the pending bit of level n at bit n (bits 3..0), the mask of level n at bit 4+n (bits 7..4), the global enable at bit 8 and the idle flag at bit 9. Bits 15..10 read 0 whatever was written to them.
- R3: A 0-to-1 change on `req_i[n]` sets pending bit n, and the bit is visible on the read port one clock later. A request line held high does not set the bit again after it has been cleared.
- R4: A bus write loads pending bit n from write bit n: a 0 clears a pending request and a 1 posts one.
- R5: `irq_o` is 1 exactly when the idle flag is 1, the global enable is 1, and some level n has both its pending bit and its mask bit at 1.
- R6: While `irq_o` is 1, `irq_lvl_o` gives the highest level n whose pending and mask bits are both 1. Level 3 has the highest priority.
- R7: An `ack_i` pulse while `irq_o` is 1 clears the pending bit of the reported level and the idle flag at the next clock edge. An `ack_i` pulse while `irq_o` is 0 changes nothing.
- R8: An `rti_i` pulse sets the idle flag to 1 at the next clock edge.
- R9: When a write falls in the same cycle as a hardware update, the write decides the global enable and the masks. A request edge or an acknowledge decides the pending bits it touches, and an acknowledge or return strobe decides the idle flag.
- R10: When `ack_i` (taken) and `rti_i` arrive in the same cycle, the idle flag ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write enable |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read-back |
| req_i | input | 4 | External request lines, one per level |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| rti_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | Interrupt to the processor |
| irq_lvl_o | output | 2 | Level of the offered interrupt |

## Verification
The bench holds a request line high after software has cleared its pending bit. A design that detected levels rather than edges would set the bit again on the next clock. It changes masks one at a time under several pending patterns, which exposes an encoder that grants a masked level or lets the lowest level win. It sends an acknowledge while no interrupt is offered, which a design that did not gate the strobe would use to drop the idle flag. It also collides writes with request edges, acknowledges and return strobes, and sends acknowledge and return together; a wrong priority at any of these shows up as a wrong read-back word.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
   localparam int unsigned REG_W    = 16;
   localparam int unsigned LEVELS   = 4;
   localparam int unsigned PEND_LSB = 0;
   localparam int unsigned MASK_LSB = PEND_LSB + LEVELS;
   localparam int unsigned EN_BIT   = MASK_LSB + LEVELS;
   localparam int unsigned IDLE_BIT = EN_BIT + 1;
   localparam int unsigned USED_W   = IDLE_BIT + 1;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_i,
   output logic [N-1:0] rise_o
);
   logic [N-1:0] prev_q;

   for (genvar n = 0; n < N; n++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q[n] <= 1'b0;
         else        prev_q[n] <= req_i[n];
      end
      assign rise_o[n] = req_i[n] & ~prev_q[n];
   end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] rise_i,
   input  logic [N-1:0] clr_i,
   input  logic         we_i,
   input  logic [N-1:0] wdata_i,
   output logic [N-1:0] pend_o
);
   for (genvar n = 0; n < N; n++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          pend_o[n] <= 1'b0;
         else if (rise_i[n])  pend_o[n] <= 1'b1;
         else if (clr_i[n])   pend_o[n] <= 1'b0;
         else if (we_i)       pend_o[n] <= wdata_i[n];
      end
   end

   // R3: an edge always leaves its pending bit set
   p_edge_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_i != '0) |=> ((pend_o & $past(rise_i)) == $past(rise_i)));
   // R9: an acknowledge clear beats a write of 1 on the same bit
   p_clear_beats_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i != '0 && (clr_i & rise_i) == '0) |=> ((pend_o & $past(clr_i)) == '0));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int unsigned N         = 4,
   parameter bit          HIGH_WINS = 1'b1,
   localparam int unsigned LW       = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  cand_i,
   output logic          valid_o,
   output logic [LW-1:0] lvl_o
);
   if (HIGH_WINS) begin : g_high
      always_comb begin
         valid_o = 1'b0;
         lvl_o   = '0;
         for (int i = 0; i < N; i++) begin
            if (cand_i[i]) begin
               valid_o = 1'b1;
               lvl_o   = LW'(i);
            end
         end
      end
   end else begin : g_low
      always_comb begin
         valid_o = 1'b0;
         lvl_o   = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
               valid_o = 1'b1;
               lvl_o   = LW'(i);
            end
         end
      end
   end

   // R6: the reported level is itself a candidate
   always_comb begin
      if (valid_o) p_lvl_is_cand_r6: assert (cand_i[lvl_o]);
   end
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
   import irq_ctrl_pkg::*;
#(
   parameter int unsigned DATA_W   = REG_W,
   parameter int unsigned NUM_LVL  = LEVELS,
   localparam int unsigned LVL_W   = $clog2(NUM_LVL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_LVL-1:0] req_i,
   input  logic              ack_i,
   input  logic              rti_i,
   output logic              irq_o,
   output logic [LVL_W-1:0]  irq_lvl_o
);
   if (DATA_W != REG_W) begin : g_bad_width
      $error("irq_ctrl_reg: DATA_W must equal the packed layout width");
   end
   if (NUM_LVL != LEVELS) begin : g_bad_levels
      $error("irq_ctrl_reg: NUM_LVL must equal the packed level count");
   end

   logic [NUM_LVL-1:0] rise;
   logic [NUM_LVL-1:0] pend;
   logic [NUM_LVL-1:0] clr;
   logic [NUM_LVL-1:0] mask_q;
   logic [NUM_LVL-1:0] cand;
   logic               en_q;
   logic               idle_q;
   logic               any_cand;
   logic               take;
   logic               unused_hi;

   assign unused_hi = ^bus_wdata[DATA_W-1:USED_W];

   irq_edge_det #(.N(NUM_LVL)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (req_i),
      .rise_o (rise)
   );

   irq_pend_bank #(.N(NUM_LVL)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise_i  (rise),
      .clr_i   (clr),
      .we_i    (bus_we),
      .wdata_i (bus_wdata[PEND_LSB +: NUM_LVL]),
      .pend_o  (pend)
   );

   assign cand = pend & mask_q;

   irq_prio_enc #(.N(NUM_LVL), .HIGH_WINS(1'b1)) u_prio (
      .cand_i  (cand),
      .valid_o (any_cand),
      .lvl_o   (irq_lvl_o)
   );

   assign irq_o = idle_q & en_q & any_cand;
   assign take  = ack_i & irq_o;

   for (genvar n = 0; n < NUM_LVL; n++) begin : g_clr
      assign clr[n] = take && (irq_lvl_o == LVL_W'(n));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mask_q <= '0;
      end else if (bus_we) begin
         en_q   <= bus_wdata[EN_BIT];
         mask_q <= bus_wdata[MASK_LSB +: NUM_LVL];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idle_q <= 1'b1;
      else if (take)   idle_q <= 1'b0;
      else if (rti_i)  idle_q <= 1'b1;
      else if (bus_we) idle_q <= bus_wdata[IDLE_BIT];
   end

   always_comb begin
      bus_rdata                         = '0;
      bus_rdata[PEND_LSB +: NUM_LVL]    = pend;
      bus_rdata[MASK_LSB +: NUM_LVL]    = mask_q;
      bus_rdata[EN_BIT]                 = en_q;
      bus_rdata[IDLE_BIT]               = idle_q;
   end

   // R7: a taken acknowledge enters the handler state
   p_ack_drops_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && irq_o) |=> !bus_rdata[IDLE_BIT]);
   // R7: a taken acknowledge retires the granted level
   p_ack_clears_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && irq_o && !rise[irq_lvl_o]) |=> !pend[$past(irq_lvl_o)]);
   // R8: a return strobe without acknowledge leaves the handler state
   p_rti_sets_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rti_i && !ack_i) |=> bus_rdata[IDLE_BIT]);
   // R5: no delivery during a handler
   p_no_irq_in_handler_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && irq_o && !bus_we) |=> !irq_o);
   // R9: without a write the enable and masks hold
   p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> $stable(bus_rdata[EN_BIT:MASK_LSB]));
endmodule

// File: tb/sim_irq_ctrl_reg.sv
module sim_irq_ctrl_reg;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 5000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [3:0]  req_i = '0;
   logic        ack_i = 1'b0;
   logic        rti_i = 1'b0;
   logic        irq_o;
   logic [1:0]  irq_lvl_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_ctrl_reg u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .req_i(req_i), .ack_i(ack_i), .rti_i(rti_i),
      .irq_o(irq_o), .irq_lvl_o(irq_lvl_o)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   // drive inputs for one clock, then clear the strobes; sampling follows at a negedge
   task automatic cycle(input logic we, input logic [15:0] wd, input logic ack, input logic rti);
      bus_we = we; bus_wdata = wd; ack_i = ack; rti_i = rti;
      @(negedge clk);
      bus_we = 1'b0; ack_i = 1'b0; rti_i = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 read word", bus_rdata, 16'h0200);
      chk("R1 irq", {15'b0, irq_o}, 16'h0);
   endtask

   task automatic t_layout();
      cycle(1'b1, 16'hFFFF, 1'b0, 1'b0);
      chk("R2 unused bits zero", bus_rdata, 16'h03FF);
      chk("R5 irq all set", {15'b0, irq_o}, 16'h1);
      chk("R6 level 3 wins", {14'b0, irq_lvl_o}, 16'h3);
      cycle(1'b1, 16'h0000, 1'b0, 1'b0);
      chk("R4 write zero clears", bus_rdata, 16'h0000);
      chk("R5 irq off", {15'b0, irq_o}, 16'h0);
   endtask

   task automatic t_edge();
      cycle(1'b1, 16'h02F0, 1'b0, 1'b0);
      req_i = 4'b0010;
      @(negedge clk);
      chk("R3 edge sets pending", bus_rdata, 16'h02F2);
      chk("R5 enable off blocks", {15'b0, irq_o}, 16'h0);
      cycle(1'b1, 16'h02F0, 1'b0, 1'b0);
      chk("R4 clear while held", bus_rdata, 16'h02F0);
      @(negedge clk);
      chk("R3 held line no reset", bus_rdata, 16'h02F0);
      req_i = 4'b0000;
      @(negedge clk);
   endtask

   task automatic t_prio();
      cycle(1'b1, 16'h03F5, 1'b0, 1'b0);
      chk("R6 level 2 of 0101", {15'b0, irq_o, 14'b0, irq_lvl_o}, {15'b0, 1'b1, 14'b0, 2'd2});
      cycle(1'b1, 16'h03B5, 1'b0, 1'b0);
      chk("R6 mask 2 off gives 0", {15'b0, irq_o, 14'b0, irq_lvl_o}, {15'b0, 1'b1, 14'b0, 2'd0});
      cycle(1'b1, 16'h0305, 1'b0, 1'b0);
      chk("R5 all masked", {15'b0, irq_o}, 16'h0);
      cycle(1'b1, 16'h01F5, 1'b0, 1'b0);
      chk("R5 in handler blocks", {15'b0, irq_o}, 16'h0);
   endtask

   task automatic t_ack();
      cycle(1'b1, 16'h03FA, 1'b0, 1'b0);
      chk("R6 level 3 of 1010", {14'b0, irq_lvl_o}, 16'h3);
      cycle(1'b0, 16'h0000, 1'b1, 1'b0);
      chk("R7 ack clears pend and idle", bus_rdata, 16'h01F2);
      chk("R7 irq off after ack", {15'b0, irq_o}, 16'h0);
      cycle(1'b0, 16'h0000, 1'b0, 1'b1);
      chk("R8 return sets idle", bus_rdata, 16'h03F2);
      chk("R8 next level offered", {15'b0, irq_o, 14'b0, irq_lvl_o}, {15'b0, 1'b1, 14'b0, 2'd1});
      cycle(1'b1, 16'h03F0, 1'b0, 1'b0);
      cycle(1'b0, 16'h0000, 1'b1, 1'b0);
      chk("R7 ack without irq ignored", bus_rdata, 16'h03F0);
   endtask

   task automatic t_collide();
      req_i = 4'b0100;
      cycle(1'b1, 16'h0300, 1'b0, 1'b0);
      chk("R9 edge beats write", bus_rdata, 16'h0304);
      req_i = 4'b0000;
      cycle(1'b1, 16'h03F4, 1'b0, 1'b0);
      cycle(1'b1, 16'h03F4, 1'b1, 1'b0);
      chk("R9 ack beats write", bus_rdata, 16'h01F0);
      cycle(1'b1, 16'h01F0, 1'b0, 1'b1);
      chk("R9 return beats write", bus_rdata, 16'h03F0);
      cycle(1'b1, 16'h03F8, 1'b0, 1'b0);
      cycle(1'b0, 16'h0000, 1'b1, 1'b1);
      chk("R10 ack and return", bus_rdata, 16'h01F0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_layout();
      t_edge();
      t_prio();
      t_ack();
      t_collide();
      finish_run();
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule